// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Sequencer

This block runs one DMA channel that walks a linked list of descriptors in memory. Software programs the channel through a small word-addressed register port: it enables the channel, loads the address of the first descriptor and writes the doorbell register. The channel then reads the eight-word descriptor and checks its valid flag. If the descriptor is valid, the channel copies the programmed number of bytes, one 32-bit word at a time, from an incrementing source address to an incrementing destination address. It then performs the status writeback that the descriptor selects, optionally clears the descriptor's valid flag in memory, flags completion and follows the next-descriptor pointer. The walk ends when the channel reaches a descriptor whose valid flag is clear. The channel then halts until the next doorbell.

Memory is reached through a single request port. A request (`mem_req`, `mem_we`, `mem_addr`, `mem_wdata`) is held until the cycle in which `mem_ack` is high. Read data is taken from `mem_rdata` in that same cycle.

The controller is a state machine with these states:
- S_IDLE: the channel is halted.
- S_FETCH: eight descriptor word reads.
- S_DECODE: the valid check.
- S_READ and S_WRITE: one data word each.
- S_STATWB: the status writeback.
- S_CLRVALID: clears the valid flag in memory.
- S_NEXT: completion and pointer load.

It has these transitions:
- S_IDLE→S_FETCH on an accepted doorbell.
- S_FETCH→S_DECODE after the eighth word is acknowledged.
- S_DECODE→S_IDLE when the descriptor is invalid.
- S_DECODE→S_STATWB when the byte count is zero.
- S_DECODE→S_READ otherwise.
- S_READ→S_WRITE on acknowledge.
- S_WRITE→S_READ while more than four bytes remain.
- S_WRITE→S_STATWB on the last word.
- S_STATWB→S_CLRVALID.
- S_CLRVALID→S_NEXT.
- S_NEXT→S_FETCH.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset:
  - the status register reads 0x1, so the channel is halted, not valid and has no doorbell;
  - the interrupt-flag register and the residual register read 0;
  - `irq` is low and `mem_req` is low.
- R2: Register word indices: 0 is configuration (bit 0 enables the channel), 1 is the descriptor pointer, 2 is the status pointer, 3 is the doorbell, 4 is the interrupt flag, 5 is the status and 6 is the residual byte count.
  - A write of any data to index 3 while the channel is halted and enabled starts the channel and sets the doorbell bit (status bit 2).
  - A doorbell while the channel is disabled issues no memory request, and the channel stays halted.
- R3: The channel fetches the 8 descriptor words from pointer+0 to pointer+28: cmd0, cmd1, source, word 3, destination, word 5, stat, next.
  - If cmd0 bit 31 is clear, the channel moves no data, makes no writeback, sets no interrupt flag and halts with status 0x1.
  - The doorbell bit clears on halt.
- R4: A valid descriptor moves ceil(cmd1[21:0]/4) words. Word k is read from source+4k and written to destination+4k. A byte count of 0 moves nothing.
- R5: cmd0[1:0] selects the writeback made after the data:
  - 0: no write;
  - 1: the status value 0x6 (doorbell and valid set, not halted);
  - 2: cmd0 with bit 31 cleared;
  - 3: the remaining byte count, which is 0 after a full transfer.
- R6: The writeback goes to the descriptor's stat word (pointer+24) when cmd0 bit 4 is 0. When bit 4 is 1 it goes to the status-pointer register with its low two address bits forced to 0. That register reads back all 32 written bits.
- R7: When cmd0 bit 2 is set, cmd0 in memory is rewritten with bit 31 cleared after the writeback.
- R8: Interrupt flag and pin:
  - Every completed descriptor sets bit 0 of the interrupt-flag register.
  - `irq` equals that flag ANDed with cmd0 bit 8 of the most recently completed descriptor.
  - Writing the flag register with bit 0 set clears the flag.
- R9: After each completion the next descriptor is fetched from the next word's bits 26:0 shifted left by 5. Higher bits are ignored. The chain continues until an invalid descriptor halts it.
- R10: A memory request keeps its address and direction until acknowledged, and every request address is word aligned.
- R11: The residual register reads the remaining byte count, and reads 0 once the channel halts after full transfers. The descriptor pointer register drops its low 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong fetch index or a wrong next-pointer capture sends later reads to the wrong descriptor. This shows up in the memory image at the end of the chain as missing or misplaced destination words, usually within one descriptor time. A bad word count or a bad address increment corrupts the last destination words or the word just after the buffer. A wrong writeback select or address leaves the wrong value at the stat word or at the status-pointer location. A stuck valid or halt flag shows up on the status register, and the channel either never halts or issues requests while halted. A lost completion shows up on the flag register and the interrupt pin once the channel halts.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 8;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int DESC_SHIFT  = IDX_W + 2;
    localparam int BASE_W      = WORD_W - DESC_SHIFT;
    localparam int WA_W        = WORD_W - 2;
    localparam int REG_AW      = 3;

    // register word indices
    localparam logic [REG_AW-1:0] REG_CFG   = 3'd0;
    localparam logic [REG_AW-1:0] REG_DESC  = 3'd1;
    localparam logic [REG_AW-1:0] REG_STATP = 3'd2;
    localparam logic [REG_AW-1:0] REG_BELL  = 3'd3;
    localparam logic [REG_AW-1:0] REG_IRQ   = 3'd4;
    localparam logic [REG_AW-1:0] REG_STS   = 3'd5;
    localparam logic [REG_AW-1:0] REG_RESID = 3'd6;

    // descriptor word slots and cmd0 fields
    localparam logic [IDX_W-1:0] W_CMD0 = 3'd0;
    localparam logic [IDX_W-1:0] W_CMD1 = 3'd1;
    localparam logic [IDX_W-1:0] W_SRC  = 3'd2;
    localparam logic [IDX_W-1:0] W_DST  = 3'd4;
    localparam logic [IDX_W-1:0] W_STAT = 3'd6;
    localparam logic [IDX_W-1:0] W_NEXT = 3'd7;
    localparam int C0_VALID = 31;
    localparam int C0_IE    = 8;
    localparam int C0_SP    = 4;
    localparam int C0_CV    = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_READ, S_WRITE, S_STATWB, S_CLRVALID, S_NEXT
    } chan_state_e;
endpackage

// File: rtl/dma_chain_regs.sv
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int BC_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              desc_load,
    input  logic [BASE_W-1:0] desc_next,
    input  logic              cpl_pulse,
    input  logic              cpl_ie,
    input  logic              sts_db,
    input  logic              sts_valid,
    input  logic              sts_halted,
    input  logic [BC_W-1:0]   residual,
    output logic              cfg_en,
    output logic [BASE_W-1:0] desc_base,
    output logic [WORD_W-1:0] stat_ptr,
    output logic              bell,
    output logic              irq_pend,
    output logic              irq
);
    logic ie_q;
    logic irq_clr;

    assign irq_clr = reg_wr && (reg_addr == REG_IRQ) && reg_wdata[0];
    assign bell    = reg_wr && (reg_addr == REG_BELL) && cfg_en;
    assign irq     = irq_pend & ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            desc_base <= '0;
            stat_ptr  <= '0;
            irq_pend  <= 1'b0;
            ie_q      <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_CFG)   cfg_en   <= reg_wdata[0];
            if (reg_wr && reg_addr == REG_STATP) stat_ptr <= reg_wdata;
            if (desc_load)
                desc_base <= desc_next;
            else if (reg_wr && reg_addr == REG_DESC)
                desc_base <= reg_wdata[WORD_W-1:DESC_SHIFT];
            if (cpl_pulse) begin
                irq_pend <= 1'b1;
                ie_q     <= cpl_ie;
            end else if (irq_clr) begin
                irq_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CFG:   reg_rdata = {{(WORD_W-1){1'b0}}, cfg_en};
            REG_DESC:  reg_rdata = {desc_base, {DESC_SHIFT{1'b0}}};
            REG_STATP: reg_rdata = stat_ptr;
            REG_IRQ:   reg_rdata = {{(WORD_W-1){1'b0}}, irq_pend};
            REG_STS:   reg_rdata = {{(WORD_W-3){1'b0}}, sts_db, sts_valid, sts_halted};
            REG_RESID: reg_rdata = WORD_W'(residual);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
    import dma_chain_pkg::*;
#(
    parameter int BC_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bell,
    input  logic [BASE_W-1:0] desc_base,
    input  logic [WA_W-1:0]   stat_word,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              desc_load,
    output logic [BASE_W-1:0] desc_next,
    output logic              cpl_pulse,
    output logic              cpl_ie,
    output logic              sts_db,
    output logic              sts_valid,
    output logic              sts_halted,
    output logic [BC_W-1:0]   residual
);
    localparam logic [BC_W-1:0] WORD_BYTES = BC_W'(WORD_W / 8);

    chan_state_e state, state_nx;
    logic [IDX_W-1:0]  widx;
    logic [WORD_W-1:0] cmd0;
    logic [BC_W-1:0]   bc_q;
    logic [WA_W-1:0]   src_w, dst_w;
    logic [WORD_W-1:0] data_q;
    logic              last_word;

    assign last_word = (residual <= WORD_BYTES);
    assign cpl_pulse = (state == S_NEXT);
    assign desc_load = (state == S_NEXT);
    assign cpl_ie    = cmd0[C0_IE];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (bell) state_nx = S_FETCH;
            S_FETCH:    if (mem_ack && widx == W_NEXT) state_nx = S_DECODE;
            S_DECODE:   if (!cmd0[C0_VALID])  state_nx = S_IDLE;
                        else if (bc_q == '0)  state_nx = S_STATWB;
                        else                  state_nx = S_READ;
            S_READ:     if (mem_ack) state_nx = S_WRITE;
            S_WRITE:    if (mem_ack) state_nx = last_word ? S_STATWB : S_READ;
            S_STATWB:   if (cmd0[1:0] == 2'd0 || mem_ack) state_nx = S_CLRVALID;
            S_CLRVALID: if (!cmd0[C0_CV] || mem_ack) state_nx = S_NEXT;
            S_NEXT:     state_nx = S_FETCH;
            default:    state_nx = S_IDLE;
        endcase
    end

    // datapath and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx       <= '0;
            cmd0       <= '0;
            bc_q       <= '0;
            src_w      <= '0;
            dst_w      <= '0;
            data_q     <= '0;
            desc_next  <= '0;
            residual   <= '0;
            sts_db     <= 1'b0;
            sts_valid  <= 1'b0;
            sts_halted <= 1'b1;
        end else begin
            unique case (state)
                S_IDLE: if (bell) begin
                    widx       <= '0;
                    sts_db     <= 1'b1;
                    sts_halted <= 1'b0;
                end
                S_FETCH: if (mem_ack) begin
                    widx <= widx + 1'b1;
                    case (widx)
                        W_CMD0:  cmd0      <= mem_rdata;
                        W_CMD1:  bc_q      <= mem_rdata[BC_W-1:0];
                        W_SRC:   src_w     <= mem_rdata[WORD_W-1:2];
                        W_DST:   dst_w     <= mem_rdata[WORD_W-1:2];
                        W_NEXT:  desc_next <= mem_rdata[BASE_W-1:0];
                        default: ;
                    endcase
                end
                S_DECODE: if (!cmd0[C0_VALID]) begin
                    sts_valid  <= 1'b0;
                    sts_halted <= 1'b1;
                    sts_db     <= 1'b0;
                end else begin
                    sts_valid <= 1'b1;
                    residual  <= bc_q;
                end
                S_READ: if (mem_ack) data_q <= mem_rdata;
                S_WRITE: if (mem_ack) begin
                    src_w    <= src_w + 1'b1;
                    dst_w    <= dst_w + 1'b1;
                    residual <= last_word ? '0 : residual - WORD_BYTES;
                end
                S_NEXT:  widx <= '0;
                default: ;
            endcase
        end
    end

    // memory request outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {desc_base, widx, 2'b00};
            end
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = {src_w, 2'b00};
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dst_w, 2'b00};
                mem_wdata = data_q;
            end
            S_STATWB: begin
                mem_req  = (cmd0[1:0] != 2'd0);
                mem_we   = 1'b1;
                mem_addr = cmd0[C0_SP] ? {stat_word, 2'b00} : {desc_base, W_STAT, 2'b00};
                case (cmd0[1:0])
                    2'd1:    mem_wdata = {{(WORD_W-3){1'b0}}, sts_db, sts_valid, sts_halted};
                    2'd2:    mem_wdata = {1'b0, cmd0[WORD_W-2:0]};
                    2'd3:    mem_wdata = WORD_W'(residual);
                    default: mem_wdata = '0;
                endcase
            end
            S_CLRVALID: begin
                mem_req   = cmd0[C0_CV];
                mem_we    = 1'b1;
                mem_addr  = {desc_base, W_CMD0, 2'b00};
                mem_wdata = {1'b0, cmd0[WORD_W-2:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int BC_W = 22
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    logic              bell, cfg_en, irq_pend;
    logic [BASE_W-1:0] desc_base, desc_next;
    logic [WORD_W-1:0] stat_ptr;
    logic              desc_load, cpl_pulse, cpl_ie;
    logic              sts_db, sts_valid, sts_halted;
    logic [BC_W-1:0]   residual;

    dma_chain_regs #(.BC_W(BC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .desc_load(desc_load), .desc_next(desc_next),
        .cpl_pulse(cpl_pulse), .cpl_ie(cpl_ie),
        .sts_db(sts_db), .sts_valid(sts_valid), .sts_halted(sts_halted), .residual(residual),
        .cfg_en(cfg_en), .desc_base(desc_base), .stat_ptr(stat_ptr),
        .bell(bell), .irq_pend(irq_pend), .irq(irq)
    );

    dma_chain_ctrl #(.BC_W(BC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bell(bell),
        .desc_base(desc_base), .stat_word(stat_ptr[WORD_W-1:2]),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .desc_load(desc_load), .desc_next(desc_next),
        .cpl_pulse(cpl_pulse), .cpl_ie(cpl_ie),
        .sts_db(sts_db), .sts_valid(sts_valid), .sts_halted(sts_halted), .residual(residual)
    );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        sts_halted,
    input logic        irq_pend,
    input logic        cfg_en
);
    logic bell_wr;
    assign bell_wr = reg_wr && (reg_addr == 3'd3);

    // R10: a pending request keeps its address and direction
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R10: word-aligned addresses
    a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R3: a halted channel issues no memory traffic
    a_r3_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sts_halted |-> !mem_req);

    // R2: doorbell ignored while disabled
    a_r2_bell_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        sts_halted && bell_wr && !cfg_en |=> sts_halted);

    // R2: doorbell starts an enabled halted channel
    a_r2_bell_start: assert property (@(posedge clk) disable iff (!rst_n)
        sts_halted && bell_wr && cfg_en |=> !sts_halted);

    // R8: completion flag rises only while the channel runs
    a_r8_flag_running: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pend) |-> !sts_halted);
endmodule

bind dma_chain_seq dma_chain_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .sts_halted(sts_halted), .irq_pend(irq_pend), .cfg_en(cfg_en)
);

// File: tb/dma_chain_seq_tb_top.sv
`timescale 1ns/100ps
module dma_chain_seq_tb_top;
    localparam logic [31:0] STATP = 32'h0000_0C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    dma_chain_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] mem     [0:1023];
    logic [31:0] exp_mem [0:1023];
    int req_cnt = 0;
    int hs_viol = 0;
    bit prev_pend = 1'b0;
    logic [31:0] prev_addr = '0;

    int      d_bc [4];
    bit [1:0] d_st [4];
    bit      d_cv [4];
    bit      d_ie [4];
    bit      d_sp [4];

    // memory model with random wait states; also watches the handshake
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) hs_viol++;
            if (mem_req) req_cnt++;
        end
        mem_ack = 1'b0;
        if (mem_req && ($urandom_range(3, 0) != 0)) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[11:2]];
        end
        prev_pend = mem_req && !mem_ack;
        prev_addr = mem_addr;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic void put(input int idx, input logic [31:0] v);
        mem[idx] = v;
        exp_mem[idx] = v;
    endfunction

    function automatic int first_diff();
        for (int k = 0; k < 1024; k++)
            if (mem[k] !== exp_mem[k]) return k;
        return -1;
    endfunction

    function automatic logic [31:0] wb_value(input bit [1:0] st, input logic [31:0] c0);
        case (st)
            2'd1:    return 32'h6;
            2'd2:    return c0 & 32'h7FFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    task automatic wait_halt();
        logic [31:0] v;
        for (int k = 0; k < 6000; k++) begin
            reg_read(3'd5, v);
            if (v[0]) break;
        end
    endtask

    // Builds n valid descriptors plus a terminating invalid one, runs them and checks.
    task automatic run_chain(input int n, input int slot, input string tg);
        logic [31:0] c0, v;
        int da, sw, dw, tgt, fd;
        for (int k = 256; k < 1024; k++) begin
            v = $urandom;
            put(k, v);
        end
        for (int i = 0; i <= n; i++) begin
            da = (slot + i) * 8;
            if (i < n)
                c0 = ($urandom & 32'h7FF0_0000) | 32'h8000_0000 | (32'(d_ie[i]) << 8) |
                     (32'(d_sp[i]) << 4) | (32'(d_cv[i]) << 2) | 32'(d_st[i]);
            else
                c0 = $urandom & 32'h7FFF_FFFF;
            put(da + 0, c0);
            put(da + 1, ($urandom & 32'hFFC0_0000) | 32'(d_bc[i]));
            put(da + 2, 32'h400 + 32'(i * 64));
            put(da + 3, $urandom);
            put(da + 4, 32'h800 + 32'(i * 64));
            put(da + 5, $urandom);
            put(da + 6, $urandom);
            put(da + 7, ($urandom & 32'hF800_0000) | 32'(slot + i + 1));
        end
        // expected memory after the chain
        for (int i = 0; i < n; i++) begin
            da = (slot + i) * 8;
            sw = (32'h400 + i * 64) >> 2;
            dw = (32'h800 + i * 64) >> 2;
            for (int w = 0; w < (d_bc[i] + 3) / 4; w++) exp_mem[dw + w] = exp_mem[sw + w];
            if (d_st[i] != 2'd0) begin
                tgt = d_sp[i] ? int'(STATP >> 2) : da + 6;
                exp_mem[tgt] = wb_value(d_st[i], exp_mem[da]);
            end
            if (d_cv[i]) exp_mem[da][31] = 1'b0;
        end
        reg_write(3'd1, 32'(slot * 32));
        reg_write(3'd3, $urandom);
        wait_halt();
        fd = first_diff();
        if (fd < 0) chk(1'b1, {tg, " R4 R5 R6 R7 R9 memory image"}, 0, 0);
        else chk(1'b0, {tg, " R4 R5 R6 R7 R9 memory image word"}, mem[fd], exp_mem[fd]);
        reg_read(3'd5, v);
        chk(v == 32'h1, {tg, " R3 halted status"}, v, 32'h1);
        reg_read(3'd4, v);
        chk(v == 32'(n > 0), {tg, " R8 flag"}, v, 32'(n > 0));
        #1;
        chk(irq == ((n > 0) && d_ie[n > 0 ? n - 1 : 0]), {tg, " R8 irq pin"}, 32'(irq),
            32'((n > 0) && d_ie[n > 0 ? n - 1 : 0]));
        reg_read(3'd6, v);
        chk(v == 32'h0, {tg, " R11 residual"}, v, 32'h0);
        reg_write(3'd4, 32'h1);
        reg_read(3'd4, v);
        #1;
        chk(v == 32'h0 && irq == 1'b0, {tg, " R8 clear"}, {v[30:0], irq}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int rc;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 1024; k++) put(k, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(3'd5, v);  chk(v == 32'h1, "R1 status after reset", v, 32'h1);
        reg_read(3'd4, v);  chk(v == 32'h0, "R1 flag after reset", v, 32'h0);
        reg_read(3'd6, v);  chk(v == 32'h0, "R1 residual after reset", v, 32'h0);
        chk(irq == 1'b0 && mem_req == 1'b0, "R1 irq/mem_req low", {30'b0, irq, mem_req}, 32'h0);

        // R11 / R6 pointer register readback
        reg_write(3'd1, 32'h0000_013F);
        reg_read(3'd1, v);  chk(v == 32'h0000_0120, "R11 desc pointer low bits", v, 32'h120);
        reg_write(3'd2, STATP | 32'h3);
        reg_read(3'd2, v);  chk(v == (STATP | 32'h3), "R6 status pointer readback", v, STATP | 32'h3);

        // R2 doorbell while disabled
        rc = req_cnt;
        reg_write(3'd3, 32'h0);
        repeat (20) @(negedge clk);
        reg_read(3'd5, v);
        chk(v == 32'h1, "R2 disabled doorbell status", v, 32'h1);
        chk(req_cnt == rc, "R2 disabled doorbell requests", 32'(req_cnt - rc), 32'h0);

        reg_write(3'd0, 32'h1);
        reg_read(3'd0, v);  chk(v == 32'h1, "R2 enable readback", v, 32'h1);

        // R3 invalid first descriptor
        run_chain(0, 3, "R3 invalid first");

        // zero byte count with byte-count writeback and clear-valid
        d_bc[0] = 0; d_st[0] = 2'd3; d_cv[0] = 1'b1; d_ie[0] = 1'b1; d_sp[0] = 1'b0;
        run_chain(1, 5, "R4 zero count");

        // three-descriptor chain, status codes 1, 2, 0
        d_bc[0] = 9;  d_st[0] = 2'd1; d_cv[0] = 1'b0; d_ie[0] = 1'b0; d_sp[0] = 1'b0;
        d_bc[1] = 16; d_st[1] = 2'd2; d_cv[1] = 1'b1; d_ie[1] = 1'b0; d_sp[1] = 1'b0;
        d_bc[2] = 1;  d_st[2] = 2'd0; d_cv[2] = 1'b0; d_ie[2] = 1'b1; d_sp[2] = 1'b1;
        run_chain(3, 10, "R9 chain of three");

        // writeback to status pointer, interrupt disabled
        d_bc[0] = 13; d_st[0] = 2'd1; d_cv[0] = 1'b0; d_ie[0] = 1'b0; d_sp[0] = 1'b1;
        run_chain(1, 0, "R6 stat pointer");

        // random chains
        for (int it = 0; it < 30; it++) begin
            int n;
            n = $urandom_range(3, 0);
            for (int i = 0; i < 4; i++) begin
                d_bc[i] = ($urandom_range(7, 0) == 0) ? 0 : $urandom_range(40, 1);
                d_st[i] = 2'($urandom);
                d_cv[i] = 1'($urandom);
                d_ie[i] = 1'($urandom);
                d_sp[i] = 1'($urandom);
            end
            run_chain(n, $urandom_range(20, 0), "random");
        end

        chk(hs_viol == 0, "R10 request held until ack", 32'(hs_viol), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule